// File: doc/BRIEF.md
# Strap-Latched Clock Mode Selector

This block sets the operating mode of a clock generator's output stage. Two plain select pins, an active-low test pin and a frequency-select pin, give a two-bit mode. The four modes are: all outputs floated, a test mode that derives the outputs from the test clock, and two normal modes with the CPU clock at either 66.6 MHz or 100 MHz. In test mode the test clock is the block clock `clk`, which is the clock arriving at the crystal input. In the normal modes the CPU and PCI outputs pass through the synthesizer clocks given on `pll_cpu_i` and `pll_pci_i`, and the PCI clock stays at 33.3 MHz in both.

Two configuration straps share pins with the reference clock outputs. After reset is released the block waits a fixed settle count. It then samples both straps on one clock edge and keeps them until the next reset. Only after that capture does the reference group start driving its pins. The spread-spectrum strap is reduced to a status flag. The 48/24 strap chooses whether the shared USB-rate output carries the 48 MHz input directly or a toggle-divided 24 MHz copy of it. All ports are plain control or clock levels. No port carries a data stream, so there is no valid/ready handshake.

Top module: `clk_mode_selector`

## Requirements
- R1: When `mode_o` is 0 (tri-state), `cpu_oe_o`, `pci_oe_o` and `ref_oe_o` are 0, and `cpu_clk_o`, `pci_clk_o` and `ref_clk_o` are held low.
- R2: When `mode_o` is 1 (test), counting the clock edges after the edge that loaded the mode as k = 1, 2, ..., `cpu_clk_o` equals 1 for odd k (clock/2). `pci_clk_o` equals 1 when (k-1) mod 6 is below 3 (clock/6, 50% duty). `ref_clk_o` follows `clk`.
- R3: When `mode_o` is 2 or 3 (normal), `cpu_clk_o` follows `pll_cpu_i` and `pci_clk_o` follows `pll_pci_i`, with the CPU and PCI groups enabled.
- R4: `mode_o` equals {`test_n_i`, `fsel_i`} sampled at the previous clock edge: 0 is tri-state, 1 is test, 2 is normal with a 66.6 MHz CPU clock, 3 is normal with a 100 MHz CPU clock.
- R5: During reset `spread_en_o` is 0 and `sel48_o` is 1. On the 8th rising clock edge after `rst_n` goes high, the block captures `spread_en_o` = NOT `strap_spread_n_i` and `sel48_o` = NOT `strap_sel48_n_i`. The straps are active low.
- R6: After capture, changes on the strap pins do not affect `spread_en_o` or `sel48_o` until the next reset.
- R7: `ref_oe_o` is 0 before the strap capture. After the capture it is 1 in every mode except tri-state.
- R8: With `sel48_o` = 1, `usb_clk_o` follows `clk48_i`. With `sel48_o` = 0, `usb_clk_o` is a toggle divider that changes level on each rising edge of `clk48_i`.
- R9: The test dividers are cleared whenever the mode is not test, so every entry into test mode restarts both divided clocks with the phase given in R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Crystal or test clock; all control state runs on it |
| rst_n | input | 1 | Active-low asynchronous reset |
| test_n_i | input | 1 | Active-low test / output-float select |
| fsel_i | input | 1 | Frequency select (0 = 66.6 MHz CPU clock, 1 = 100 MHz CPU clock) |
| strap_spread_n_i | input | 1 | Pin value of the spread strap, active low |
| strap_sel48_n_i | input | 1 | Pin value of the 48/24 strap, active low |
| clk48_i | input | 1 | 48 MHz source clock |
| pll_cpu_i | input | 1 | Synthesized CPU clock used in normal modes |
| pll_pci_i | input | 1 | Synthesized PCI clock used in normal modes |
| mode_o | output | 2 | Registered mode code |
| spread_en_o | output | 1 | Spread spectrum enabled (captured strap) |
| sel48_o | output | 1 | 1 = 48 MHz on the USB-rate output, 0 = 24 MHz |
| cpu_clk_o | output | 1 | CPU clock group level |
| pci_clk_o | output | 1 | PCI clock group level |
| ref_clk_o | output | 1 | Reference clock group level |
| usb_clk_o | output | 1 | 48 or 24 MHz output level |
| cpu_oe_o | output | 1 | CPU group drive enable |
| pci_oe_o | output | 1 | PCI group drive enable |
| ref_oe_o | output | 1 | Reference group drive enable; low while the straps are read |

## Verification
A wrong mode register shows on `mode_o` and the enables on the very next edge. A mis-phased or uncleared divider shows on `cpu_clk_o` within one edge of entering test mode, and on `pci_clk_o` within three edges. An off-by-one settle counter moves the rise of `ref_oe_o` and the change of the strap flags by one edge, which a check at each of the first eight edges catches. A strap register that keeps sampling shows on the flags the edge after the pins change. A stuck 24 MHz toggle shows on `usb_clk_o` within two `clk48_i` edges.

// File: rtl/clk_mode_pkg.sv
package clk_mode_pkg;
  typedef enum logic [1:0] {
    MODE_HIZ  = 2'b00,
    MODE_TEST = 2'b01,
    MODE_N66  = 2'b10,
    MODE_N100 = 2'b11
  } out_mode_e;
endpackage

// File: rtl/strap_latch.sv
module strap_latch #(
  parameter int SETTLE_CYCLES = 8,
  parameter int NUM_STRAPS    = 2,
  parameter logic [NUM_STRAPS-1:0] RESET_VALUE = '0
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_STRAPS-1:0] pin_n_i,
  output logic [NUM_STRAPS-1:0] flag_o,
  output logic                  done_o
);
  localparam int CNT_W = $clog2(SETTLE_CYCLES + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(SETTLE_CYCLES - 1);

  logic [CNT_W-1:0]      cnt_q;
  logic                  done_q;
  logic [NUM_STRAPS-1:0] flag_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
      flag_q <= RESET_VALUE;
    end else if (!done_q) begin
      if (cnt_q == LAST) begin
        done_q <= 1'b1;
        flag_q <= ~pin_n_i;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign flag_o = flag_q;
  assign done_o = done_q;

  // R6: captured flags never move again until reset
  p_straps_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> $stable(flag_q));
  // R5: capture completes exactly once
  p_done_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> done_q);
endmodule

// File: rtl/test_divider.sv
module test_divider #(
  parameter int DIV = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  output logic out_o
);
  generate
    if (DIV < 2) begin : g_pass
      assign out_o = run_i & clk;
    end else begin : g_count
      localparam int CNT_W = $clog2(DIV);
      localparam logic [CNT_W-1:0] HALF = CNT_W'(DIV / 2);
      localparam logic [CNT_W-1:0] TOP  = CNT_W'(DIV - 1);
      logic [CNT_W-1:0] cnt_q;
      logic             out_q;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          cnt_q <= '0;
          out_q <= 1'b0;
        end else if (!run_i) begin
          cnt_q <= '0;
          out_q <= 1'b0;
        end else begin
          cnt_q <= (cnt_q == TOP) ? '0 : cnt_q + 1'b1;
          out_q <= (cnt_q < HALF);
        end
      end
      assign out_o = out_q;

      // R9: divider output is low the edge after it is stopped
      p_div_held_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> !out_q);
      // R2: first divided edge after a restart is high
      p_div_starts_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(run_i)) |=> out_q);
    end
  endgenerate
endmodule

// File: rtl/rate_halver.sv
module rate_halver (
  input  logic clk_in,
  input  logic rst_n,
  output logic half_o
);
  logic tog_q;
  always_ff @(posedge clk_in or negedge rst_n) begin
    if (!rst_n) tog_q <= 1'b0;
    else        tog_q <= ~tog_q;
  end
  assign half_o = tog_q;

  // R8: toggle flips on every source edge
  p_toggle_flips_r8: assert property (@(posedge clk_in) disable iff (!rst_n)
    1'b1 |=> (tog_q != $past(tog_q)));
endmodule

// File: rtl/clk_mode_selector.sv
module clk_mode_selector
  import clk_mode_pkg::*;
#(
  parameter int SETTLE_CYCLES = 8,
  parameter int CPU_TEST_DIV  = 2,
  parameter int PCI_TEST_DIV  = 6
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       test_n_i,
  input  logic       fsel_i,
  input  logic       strap_spread_n_i,
  input  logic       strap_sel48_n_i,
  input  logic       clk48_i,
  input  logic       pll_cpu_i,
  input  logic       pll_pci_i,
  output logic [1:0] mode_o,
  output logic       spread_en_o,
  output logic       sel48_o,
  output logic       cpu_clk_o,
  output logic       pci_clk_o,
  output logic       ref_clk_o,
  output logic       usb_clk_o,
  output logic       cpu_oe_o,
  output logic       pci_oe_o,
  output logic       ref_oe_o
);
  localparam int NUM_STRAPS = 2;
  localparam logic [NUM_STRAPS-1:0] STRAP_RST = 2'b10; // {sel48, spread}

  out_mode_e mode_q;
  logic [NUM_STRAPS-1:0] flags;
  logic straps_done;
  logic test_run, drive_en;
  logic cpu_div, pci_div, clk24;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= MODE_N100;
    else        mode_q <= out_mode_e'({test_n_i, fsel_i});
  end

  strap_latch #(
    .SETTLE_CYCLES(SETTLE_CYCLES),
    .NUM_STRAPS   (NUM_STRAPS),
    .RESET_VALUE  (STRAP_RST)
  ) u_straps (
    .clk    (clk),
    .rst_n  (rst_n),
    .pin_n_i({strap_sel48_n_i, strap_spread_n_i}),
    .flag_o (flags),
    .done_o (straps_done)
  );

  assign test_run = (mode_q == MODE_TEST);
  assign drive_en = (mode_q != MODE_HIZ);

  test_divider #(.DIV(CPU_TEST_DIV)) u_cpu_div (
    .clk(clk), .rst_n(rst_n), .run_i(test_run), .out_o(cpu_div));
  test_divider #(.DIV(PCI_TEST_DIV)) u_pci_div (
    .clk(clk), .rst_n(rst_n), .run_i(test_run), .out_o(pci_div));

  rate_halver u_half (.clk_in(clk48_i), .rst_n(rst_n), .half_o(clk24));

  always_comb begin
    cpu_clk_o = 1'b0;
    pci_clk_o = 1'b0;
    unique case (mode_q)
      MODE_TEST: begin
        cpu_clk_o = cpu_div;
        pci_clk_o = pci_div;
      end
      MODE_N66, MODE_N100: begin
        cpu_clk_o = pll_cpu_i;
        pci_clk_o = pll_pci_i;
      end
      default: ;
    endcase
  end

  assign mode_o      = mode_q;
  assign spread_en_o = flags[0];
  assign sel48_o     = flags[1];
  assign cpu_oe_o    = drive_en;
  assign pci_oe_o    = drive_en;
  assign ref_oe_o    = drive_en & straps_done;
  assign ref_clk_o   = ref_oe_o & clk;
  assign usb_clk_o   = sel48_o ? clk48_i : clk24;

  // R4: mode code follows the pins one edge later
  p_mode_track_r4: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (mode_o == $past({test_n_i, fsel_i})));
  // R1: floated groups stay low
  p_hiz_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_HIZ) |-> (!cpu_clk_o && !pci_clk_o && !ref_oe_o));
  // R7: reference pins never drive while straps are being read
  p_ref_wait_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !straps_done |-> !ref_oe_o);
endmodule

// File: tb/clk_mode_selector_bench.sv
module clk_mode_selector_bench;
  logic clk = 1'b0;
  logic clk48 = 1'b0;
  logic rst_n = 1'b0;
  logic test_n = 1'b1, fsel = 1'b1;
  logic sp_n = 1'b1, s48_n = 1'b1;
  logic pcpu = 1'b0, ppci = 1'b0;
  logic [1:0] mode;
  logic spread, sel48, cpu_c, pci_c, ref_c, usb_c, cpu_oe, pci_oe, ref_oe;
  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;
  always #5 clk48 = ~clk48;

  clk_mode_selector u_clk_mode_selector (
    .clk(clk), .rst_n(rst_n), .test_n_i(test_n), .fsel_i(fsel),
    .strap_spread_n_i(sp_n), .strap_sel48_n_i(s48_n), .clk48_i(clk48),
    .pll_cpu_i(pcpu), .pll_pci_i(ppci), .mode_o(mode), .spread_en_o(spread),
    .sel48_o(sel48), .cpu_clk_o(cpu_c), .pci_clk_o(pci_c), .ref_clk_o(ref_c),
    .usb_clk_o(usb_c), .cpu_oe_o(cpu_oe), .pci_oe_o(pci_oe), .ref_oe_o(ref_oe));

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic set_mode(input int m);
    @(negedge clk);
    test_n = m[1];
    fsel   = m[0];
    step();
  endtask

  task automatic sweep_mode(input int m);
    set_mode(m);
    chk("R4 mode", mode, m);
    chk("R1/R3 cpu_oe", cpu_oe, (m != 0));
    chk("R1/R3 pci_oe", pci_oe, (m != 0));
    chk("R7 ref_oe", ref_oe, (m != 0));
    for (int k = 1; k <= 12; k++) begin
      @(negedge clk);
      pcpu = k[0];
      ppci = k[1];
      step();
      case (m)
        0: begin
          chk("R1 cpu low", cpu_c, 0);
          chk("R1 pci low", pci_c, 0);
          chk("R1 ref low", ref_c, 0);
        end
        1: begin
          chk("R2 cpu div2", cpu_c, k % 2);
          chk("R2 pci div6", pci_c, (((k - 1) % 6) < 3) ? 1 : 0);
          chk("R2 ref=clk", ref_c, 1);
        end
        default: begin
          chk("R3 cpu pass", cpu_c, k[0]);
          chk("R3 pci pass", pci_c, k[1]);
        end
      endcase
    end
  endtask

  task automatic usb_check(input int exp48);
    int prev;
    @(posedge clk48); #1;
    prev = usb_c;
    for (int i = 0; i < 6; i++) begin
      @(posedge clk48); #1;
      if (exp48 != 0) chk("R8 usb=48", usb_c, 1);
      else chk("R8 usb toggles", usb_c, prev ^ 1);
      prev = usb_c;
    end
  endtask

  initial begin
    for (int sc = 0; sc < 4; sc++) begin
      rst_n = 1'b0;
      sp_n = sc[0];
      s48_n = sc[1];
      test_n = 1'b1;
      fsel = 1'b1;
      repeat (3) @(negedge clk);
      chk("R5 reset spread", spread, 0);
      chk("R5 reset sel48", sel48, 1);
      chk("R7 reset ref_oe", ref_oe, 0);
      rst_n = 1'b1;
      for (int e = 1; e <= 8; e++) begin
        step();
        if (e < 8) begin
          chk("R7 ref_oe before capture", ref_oe, 0);
          chk("R5 spread before capture", spread, 0);
          chk("R5 sel48 before capture", sel48, 1);
        end else begin
          chk("R5 spread captured", spread, sc[0] ? 0 : 1);
          chk("R5 sel48 captured", sel48, sc[1] ? 0 : 1);
          chk("R7 ref_oe after capture", ref_oe, 1);
        end
      end
      @(negedge clk);
      sp_n = ~sp_n;
      s48_n = ~s48_n;
      repeat (3) step();
      chk("R6 spread ignores pin", spread, sc[0] ? 0 : 1);
      chk("R6 sel48 ignores pin", sel48, sc[1] ? 0 : 1);
      usb_check(sc[1] ? 0 : 1);
      for (int m = 0; m < 4; m++) sweep_mode(m);
      sweep_mode(1); // R9 re-entry restarts phase from normal mode
      sweep_mode(0);
      sweep_mode(1); // R9 re-entry from tri-state
    end
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #2_000_000;
    if (!finished) begin
      bad++;
      total++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule